// File: doc/BRIEF.md
# Configuration Address/Data Port Bridge

This block sits on the host side of a configuration fabric. It turns an 8-byte I/O window into configuration-space transactions. Software first writes a 32-bit target word to the address register at window offset 0. The word holds an enable flag, a bus number, a device number, a function number and a dword register index. Software then reads or writes bytes 4 to 7 of the window. The data-port byte it touches selects the byte lane inside the target dword. The access width (1, 2 or 4 bytes) and that lane together give the byte enables of the configuration cycle.

Each access to the data window, when it is enabled and legal, becomes one request on a simple request/response master port. The I/O side is stalled until the target responds or a timeout expires. Read data comes back shifted down to bit 0 and masked to the access width. Only one configuration transaction is ever in flight.

Top module: `cfg_port_bridge`

## Requirements
- R1: After reset `io_ready_o` and `cfg_req_o` are low and the address register reads as zero.
- R2: The address register changes only on a 4-byte write at offset 0. Narrower writes to offsets 0 to 3 are dropped. A read of offsets 0 to 3 returns the stored word shifted right by 8 times the offset and masked to the width. In the stored word bits 30:24 and 1:0 read as zero.
- R3: The address word is decoded as enable = bit 31, bus = bits 23:16, device = bits 15:11, function = bits 10:8, dword index = bits 7:2. These appear on `cfg_bus_o`, `cfg_dev_o`, `cfg_fn_o` and `cfg_dw_o`.
- R4: A data-window access at offset 4+k uses lane k. `cfg_be_o` is the width pattern (size 0 = 1 byte = 0001, size 1 = 2 bytes = 0011, size 2 = 4 bytes = 1111) shifted left by k. `cfg_wdata_o` is the write data masked to the width and shifted left by 8k bits. `cfg_we_o` carries the access direction.
- R5: A configuration read returns `cfg_rdata_i` shifted right by 8k bits and masked to the access width. A write returns zero on `io_rdata_o`.
- R6: While the enable bit is clear, a data-window access issues no configuration cycle. A read returns all ones masked to its width and a write is dropped.
- R7: An illegal access issues no transaction and leaves the address register unchanged, and a read returns all ones masked to its width. Illegal means a 2-byte access at lane 3, a 4-byte access at a nonzero lane, or size code 3 (treated as 4 bytes wide).
- R8: If `cfg_rsp_i` does not arrive within `TIMEOUT` cycles of `cfg_req_o` rising, the request is withdrawn and a read returns all ones masked to its width. The request fields stay stable while it is held.
- R9: `io_ready_o` is a one-cycle pulse that marks completion and carries valid `io_rdata_o`. It is never high while `cfg_req_o` is high, and it follows the last cycle of every configuration request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| io_req_i | input | 1 | I/O access request, held until `io_ready_o` |
| io_we_i | input | 1 | 1 = write, 0 = read |
| io_off_i | input | 3 | Byte offset inside the 8-byte window |
| io_size_i | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| io_wdata_i | input | 32 | Write data, right-aligned |
| io_rdata_o | output | 32 | Read data, right-aligned, valid with ready |
| io_ready_o | output | 1 | Completion pulse |
| cfg_req_o | output | 1 | Configuration request held until response or timeout |
| cfg_we_o | output | 1 | Configuration write |
| cfg_bus_o | output | 8 | Target bus number |
| cfg_dev_o | output | 5 | Target device number |
| cfg_fn_o | output | 3 | Target function number |
| cfg_dw_o | output | 6 | Target dword index |
| cfg_be_o | output | 4 | Byte enables |
| cfg_wdata_o | output | 32 | Lane-aligned write data |
| cfg_rsp_i | input | 1 | Target response strobe |
| cfg_rdata_i | input | 32 | Target read data, lane-aligned |

## Verification
Directed accesses cover every lane and width combination on the data window, so a wrong shift, a wrong mask or a wrong byte-enable pattern shows up in a specific lane. A full write of all ones to the address register, followed by narrow writes to it, separates the reserved-bit masking from the write qualification. Accesses with the enable bit clear, illegal width/lane pairs and a device that never answers are each told apart by the count of configuration requests issued and by the all-ones pattern at the access width. A seeded random mix of target words, offsets, widths and directions is then checked against a bench model of the target register file.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  // bits kept in the address register
  localparam logic [31:0] ADDR_KEEP = 32'h80FF_FFFC;

  typedef enum logic [1:0] {ST_IDLE, ST_CFG, ST_DONE} bridge_state_e;

  typedef struct packed {
    logic       en;
    logic [7:0] bus;
    logic [4:0] dev;
    logic [2:0] fn;
    logic [5:0] dw;
  } cfg_target_t;

  function automatic cfg_target_t unpack_target(logic [31:0] w);
    cfg_target_t t;
    t.en  = w[31];
    t.bus = w[23:16];
    t.dev = w[15:11];
    t.fn  = w[10:8];
    t.dw  = w[7:2];
    return t;
  endfunction
endpackage

// File: rtl/cfgb_lane_dec.sv
module cfgb_lane_dec
  import cfgb_pkg::*;
(
  input  logic [1:0]  lane_i,
  input  logic [1:0]  size_i,
  output logic        legal_o,
  output logic [3:0]  be_o,
  output logic [31:0] wmask_o,
  output logic [4:0]  shamt_o
);
  logic [3:0] be_base;

  always_comb begin
    be_base = 4'b0000;
    wmask_o = 32'hFFFF_FFFF;
    legal_o = 1'b0;
    case (size_i)
      SZ_BYTE: begin be_base = 4'b0001; wmask_o = 32'h0000_00FF; legal_o = 1'b1; end
      SZ_HALF: begin be_base = 4'b0011; wmask_o = 32'h0000_FFFF; legal_o = (lane_i != 2'd3); end
      SZ_WORD: begin be_base = 4'b1111; legal_o = (lane_i == 2'd0); end
      default: ;
    endcase
  end

  assign be_o    = be_base << lane_i;
  assign shamt_o = {lane_i, 3'b000};
endmodule

// File: rtl/cfgb_addr_latch.sv
module cfgb_addr_latch
  import cfgb_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (wr_i) q_o <= wdata_i & ADDR_KEEP;
  end
endmodule

// File: rtl/cfgb_timer.sv
module cfgb_timer #(
  parameter int unsigned TIMEOUT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expire_o
);
  localparam int unsigned TW = (TIMEOUT < 2) ? 1 : $clog2(TIMEOUT);
  localparam logic [TW-1:0] LAST = TW'(TIMEOUT - 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (!run_i)                  cnt_q <= '0;
    else if (cnt_q != LAST)           cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/cfg_port_bridge.sv
module cfg_port_bridge
  import cfgb_pkg::*;
#(
  parameter int unsigned TIMEOUT = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        io_req_i,
  input  logic        io_we_i,
  input  logic [2:0]  io_off_i,
  input  logic [1:0]  io_size_i,
  input  logic [31:0] io_wdata_i,
  output logic [31:0] io_rdata_o,
  output logic        io_ready_o,
  output logic        cfg_req_o,
  output logic        cfg_we_o,
  output logic [7:0]  cfg_bus_o,
  output logic [4:0]  cfg_dev_o,
  output logic [2:0]  cfg_fn_o,
  output logic [5:0]  cfg_dw_o,
  output logic [3:0]  cfg_be_o,
  output logic [31:0] cfg_wdata_o,
  input  logic        cfg_rsp_i,
  input  logic [31:0] cfg_rdata_i
);
  bridge_state_e state_q;
  logic [31:0]   addr_q, rdata_q, wdata_q, wmask_q;
  logic [3:0]    be_q;
  logic [4:0]    shamt_q;
  logic          we_q;

  logic          legal, expire, accept, latch_wr;
  logic [3:0]    be;
  logic [31:0]   wmask;
  logic [4:0]    shamt;
  cfg_target_t   tgt;

  cfgb_lane_dec u_dec (
    .lane_i (io_off_i[1:0]),
    .size_i (io_size_i),
    .legal_o(legal),
    .be_o   (be),
    .wmask_o(wmask),
    .shamt_o(shamt)
  );

  assign accept   = (state_q == ST_IDLE) && io_req_i;
  assign latch_wr = accept && io_we_i && legal && (io_off_i == 3'd0) && (io_size_i == SZ_WORD);

  cfgb_addr_latch u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (latch_wr),
    .wdata_i(io_wdata_i),
    .q_o    (addr_q)
  );

  cfgb_timer #(.TIMEOUT(TIMEOUT)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (state_q == ST_CFG),
    .expire_o(expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rdata_q <= '0;
      wdata_q <= '0;
      wmask_q <= '0;
      be_q    <= '0;
      shamt_q <= '0;
      we_q    <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (io_req_i) begin
          we_q    <= io_we_i;
          wmask_q <= wmask;
          shamt_q <= shamt;
          if (!legal) begin
            rdata_q <= io_we_i ? '0 : wmask;
            state_q <= ST_DONE;
          end else if (!io_off_i[2]) begin
            rdata_q <= io_we_i ? '0 : ((addr_q >> shamt) & wmask);
            state_q <= ST_DONE;
          end else if (!addr_q[31]) begin
            rdata_q <= io_we_i ? '0 : wmask;
            state_q <= ST_DONE;
          end else begin
            be_q    <= be;
            wdata_q <= (io_wdata_i & wmask) << shamt;
            state_q <= ST_CFG;
          end
        end
        ST_CFG: begin
          if (cfg_rsp_i) begin
            rdata_q <= we_q ? '0 : ((cfg_rdata_i >> shamt_q) & wmask_q);
            state_q <= ST_DONE;
          end else if (expire) begin
            rdata_q <= we_q ? '0 : wmask_q;
            state_q <= ST_DONE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign tgt         = unpack_target(addr_q);
  assign io_ready_o  = (state_q == ST_DONE);
  assign io_rdata_o  = rdata_q;
  assign cfg_req_o   = (state_q == ST_CFG);
  assign cfg_we_o    = we_q;
  assign cfg_bus_o   = tgt.bus;
  assign cfg_dev_o   = tgt.dev;
  assign cfg_fn_o    = tgt.fn;
  assign cfg_dw_o    = tgt.dw;
  assign cfg_be_o    = be_q;
  assign cfg_wdata_o = wdata_q;
endmodule

// File: rtl/cfgb_chk.sv
module cfgb_chk #(
  parameter int unsigned TIMEOUT = 16
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        io_ready_o,
  input logic        cfg_req_o,
  input logic [3:0]  cfg_be_o,
  input logic [31:0] cfg_wdata_o,
  input logic [5:0]  cfg_dw_o,
  input logic        latch_en_i
);
  logic [31:0] req_cnt;
  logic [31:0] lane_mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         req_cnt <= '0;
    else if (!cfg_req_o) req_cnt <= '0;
    else                 req_cnt <= req_cnt + 1;
  end

  always_comb begin
    for (int i = 0; i < 4; i++) lane_mask[8*i +: 8] = {8{cfg_be_o[i]}};
  end

  // R9
  ready_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_ready_o |=> !io_ready_o);
  // R9
  no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o |-> !io_ready_o);
  // R9
  done_after_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cfg_req_o) |-> io_ready_o);
  // R6
  req_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o |-> latch_en_i);
  // R4
  be_shape_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o |-> ($countones(cfg_be_o) == 1 || cfg_be_o == 4'b0011 ||
                   cfg_be_o == 4'b0110 || cfg_be_o == 4'b1100 || cfg_be_o == 4'b1111));
  // R4
  wdata_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o |-> ((cfg_wdata_o & ~lane_mask) == 32'd0));
  // R8
  req_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o |-> (req_cnt < TIMEOUT));
  // R8
  req_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_req_o && $past(cfg_req_o)) |-> ($stable(cfg_be_o) && $stable(cfg_dw_o) && $stable(cfg_wdata_o)));
endmodule

bind cfg_port_bridge cfgb_chk #(.TIMEOUT(TIMEOUT)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .io_ready_o (io_ready_o),
  .cfg_req_o  (cfg_req_o),
  .cfg_be_o   (cfg_be_o),
  .cfg_wdata_o(cfg_wdata_o),
  .cfg_dw_o   (cfg_dw_o),
  .latch_en_i (addr_q[31])
);

// File: tb/cfg_port_bridge_bench.sv
module cfg_port_bridge_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 16;
  localparam logic [4:0] DEAD_DEV = 5'd31;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [2:0]  off = '0;
  logic [1:0]  size = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ready;
  logic        creq, cwe;
  logic [7:0]  cbus;
  logic [4:0]  cdev;
  logic [2:0]  cfn;
  logic [5:0]  cdw;
  logic [3:0]  cbe;
  logic [31:0] cwdata;
  logic        rsp = 1'b0;
  logic [31:0] crdata = '0;

  int n_chk = 0, n_fail = 0, n_txn = 0;
  int rsp_dly = 0;
  logic [31:0] shadow = '0;
  logic        l_we;
  logic [3:0]  l_be;
  logic [31:0] l_wdata, l_fields;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_port_bridge #(.TIMEOUT(TMO)) u_cfg_port_bridge (
    .clk_i(clk), .rst_ni(rst_n),
    .io_req_i(req), .io_we_i(we), .io_off_i(off), .io_size_i(size),
    .io_wdata_i(wdata), .io_rdata_o(rdata), .io_ready_o(ready),
    .cfg_req_o(creq), .cfg_we_o(cwe), .cfg_bus_o(cbus), .cfg_dev_o(cdev),
    .cfg_fn_o(cfn), .cfg_dw_o(cdw), .cfg_be_o(cbe), .cfg_wdata_o(cwdata),
    .cfg_rsp_i(rsp), .cfg_rdata_i(crdata)
  );

  function automatic logic [31:0] model_rd(logic [7:0] b, logic [4:0] d, logic [2:0] f, logic [5:0] r);
    return {b, 3'b0, d, 5'b0, f, 2'b0, r} ^ 32'h5A3C_9617;
  endfunction

  function automatic logic [31:0] wmask_of(logic [1:0] s);
    return (s == 2'd0) ? 32'hFF : (s == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic bit legal_of(logic [1:0] s, logic [1:0] l);
    return (s == 2'd0) || (s == 2'd1 && l != 2'd3) || (s == 2'd2 && l == 2'd0);
  endfunction

  function automatic logic [3:0] be_of(logic [1:0] s, logic [1:0] l);
    logic [3:0] b = (s == 2'd0) ? 4'b0001 : (s == 2'd1) ? 4'b0011 : 4'b1111;
    return b << l;
  endfunction

  // target model
  initial begin
    int cnt = 0;
    bit seen = 0;
    forever begin
      @(negedge clk);
      if (rsp) rsp = 1'b0;
      else if (creq) begin
        if (!seen) begin
          seen = 1; n_txn++;
          l_we = cwe; l_be = cbe; l_wdata = cwdata;
          l_fields = {cbus, cdev, cfn, cdw, 10'd0};
        end
        if (cdev != DEAD_DEV) begin
          if (cnt >= rsp_dly) begin
            rsp = 1'b1; crdata = model_rd(cbus, cdev, cfn, cdw); cnt = 0;
          end else cnt++;
        end
      end else begin
        seen = 0; cnt = 0;
      end
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [2:0] o, input logic [1:0] s,
                        input logic [31:0] d, output logic [31:0] r);
    int lim = 0;
    req = 1'b1; we = w; off = o; size = s; wdata = d;
    do begin
      @(negedge clk); lim++;
    end while (!ready && lim < 200);
    r = rdata;
    if (!ready) chk(0, "R9 hang", 32'd0, 32'd1);
    req = 1'b0;
    @(negedge clk);
    chk(ready == 1'b0, "R9 pulse", {31'd0, ready}, 32'd0);
  endtask

  // one access with full expectation
  task automatic run_one(logic w, logic [2:0] o, logic [1:0] s, logic [31:0] d);
    logic [31:0] r, exp;
    logic [1:0]  l = o[1:0];
    bit lg = legal_of(s, l);
    bit issue = lg && o[2] && shadow[31];
    bit dead = (shadow[15:11] == DEAD_DEV);
    int t0 = n_txn;
    string tag;
    tag = !lg ? "R7" : !o[2] ? "R2" : !shadow[31] ? "R6" : dead ? "R8" : "R5";
    access(w, o, s, d, r);
    if (w) exp = 32'd0;
    else if (!lg) exp = wmask_of(s);
    else if (!o[2]) exp = (shadow >> {l, 3'b0}) & wmask_of(s);
    else if (!shadow[31] || dead) exp = wmask_of(s);
    else exp = (model_rd(shadow[23:16], shadow[15:11], shadow[10:8], shadow[7:2]) >> {l, 3'b0}) & wmask_of(s);
    chk(r == exp, tag, r, exp);
    chk((n_txn - t0) == (issue ? 1 : 0), {tag, " txn count"}, n_txn - t0, issue ? 1 : 0);
    if (issue) begin
      chk(l_be == be_of(s, l), "R4 be", {28'd0, l_be}, {28'd0, be_of(s, l)});
      chk(l_we == w, "R4 we", {31'd0, l_we}, {31'd0, w});
      if (w) chk(l_wdata == ((d & wmask_of(s)) << {l, 3'b0}), "R4 wdata", l_wdata, (d & wmask_of(s)) << {l, 3'b0});
      chk(l_fields == {shadow[23:2], 10'd0}, "R3 fields", l_fields, {shadow[23:2], 10'd0});
    end
    if (w && lg && o == 3'd0 && s == 2'd2) shadow = d & 32'h80FF_FFFC;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ready == 1'b0 && creq == 1'b0, "R1 outputs", {30'd0, ready, creq}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    access(1'b0, 3'd0, 2'd2, 32'd0, r);
    chk(r == 32'd0, "R1 addr", r, 32'd0);
    // R2 masking and write qualification
    run_one(1'b1, 3'd0, 2'd2, 32'hFFFF_FFFF);
    run_one(1'b0, 3'd0, 2'd2, 32'd0);
    run_one(1'b1, 3'd0, 2'd0, 32'h0000_0011);
    run_one(1'b1, 3'd1, 2'd1, 32'h0000_2222);
    run_one(1'b0, 3'd0, 2'd2, 32'd0);
    run_one(1'b0, 3'd2, 2'd1, 32'd0);
    // R3/R5 target word: bus 0x12 dev 5 fn 3 dw 0x0F, enabled
    run_one(1'b1, 3'd0, 2'd2, 32'h8012_2B3C);
    run_one(1'b0, 3'd4, 2'd2, 32'd0);
    for (int k = 4; k < 8; k++) run_one(1'b0, 3'(k), 2'd0, 32'd0);
    run_one(1'b0, 3'd6, 2'd1, 32'd0);
    run_one(1'b0, 3'd7, 2'd1, 32'd0);   // R7
    run_one(1'b0, 3'd5, 2'd2, 32'd0);   // R7
    run_one(1'b0, 3'd4, 2'd3, 32'd0);   // R7
    run_one(1'b1, 3'd6, 2'd0, 32'hDEAD_BEA5); // R4
    run_one(1'b1, 3'd5, 2'd1, 32'h1234_5678); // R4
    // R6 enable clear
    run_one(1'b1, 3'd0, 2'd2, 32'h0012_2B3C);
    run_one(1'b0, 3'd4, 2'd1, 32'd0);
    run_one(1'b1, 3'd4, 2'd2, 32'hCAFE_F00D);
    // R8 dead device
    run_one(1'b1, 3'd0, 2'd2, 32'h8003_F800);
    run_one(1'b0, 3'd6, 2'd1, 32'd0);
    run_one(1'b1, 3'd4, 2'd2, 32'h0BAD_0BAD);
    // random mix
    for (int i = 0; i < 400; i++) begin
      rsp_dly = $urandom_range(0, 3);
      if ($urandom_range(0, 3) == 0) begin
        logic [31:0] a = $urandom;
        if ($urandom_range(0, 7) != 0 && a[15:11] == DEAD_DEV) a[15:11] = 5'd2;
        if ($urandom_range(0, 5) != 0) a[31] = 1'b1;
        run_one(1'b1, 3'd0, 2'd2, a);
      end else begin
        logic [2:0] o = 3'($urandom_range(0, 7));
        if ($urandom_range(0, 3) != 0) o[2] = 1'b1;
        run_one(1'($urandom_range(0, 1)), o, 2'($urandom_range(0, 3)), $urandom);
      end
    end
    finish_run();
  end
endmodule